// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog with 32-bit word registers. A down-counter is loaded from a programmable reload register. While the watchdog is enabled, the counter decrements once per selected tick. The tick is either every peripheral clock cycle or once per microsecond, taken from a prescaler. Software keeps the watchdog alive only by writing a fixed 16-bit key to a restart register. Other values written there do nothing.

When the counter expires, the block can drive a system reset pulse. Software sets the pulse length, its active level and its drive style (push-pull, or open-drain modelled as a separate output-enable). Polarity and drive style change only when the top byte of a write to the width register carries one of four codes. An external inhibit input changes what an expiry does: the watchdog switches itself off and issues no pulse.

The control register changes only when a write flips its enable bit, so a stray write cannot re-time a running watchdog.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, word 0x00 (count) and word 0x04 (reload) read 0x03EF1480, word 0x0C (control) reads 0, word 0x18 (pulse config) reads 0x000000FF, and word 0x1C (mask) reads 0. The reset pin idles at the inactive level: rst_out=1 and rst_oe=0.
- R2: A write to 0x08 whose bits [15:0] equal 0x4755 copies the reload value into the counter. The counter runs afterwards only if control bit 0 is set. Any other value leaves the counter unchanged, and 0x08 reads 0.
- R3: A write to 0x0C is applied only when its bit 0 differs from the stored enable. A 0-to-1 write stores bits [6:0] and starts counting from the reload value. A 1-to-0 write stores them and freezes the counter. A write that leaves bit 0 unchanged is dropped.
- R4: Control bit 4 selects the tick. When it is set, the count drops once every PRESCALE clock cycles, measured from the enable or restart. When it is clear, the count drops on every clock cycle.
- R5: A running counter loaded with value N expires on its N-th tick (a load of 0 or 1 expires on the first tick). It then reads 0 and stays at 0 until it is restarted or re-enabled.
- R6: On expiry, with control bit 1 set and inhibit low, the reset output is active for exactly W clock cycles, where W is bits [19:0] of 0x18. The first active cycle follows the cycle in which the count reaches 0. If W=0, or bit 1 is clear, no pulse is issued.
- R7: Bit 31 of 0x18 selects active-high (1) or active-low (0). Bit 30 selects push-pull (1, rst_oe always 1) or open-drain (0, rst_oe=1 only while the pulse is active). rst_out equals the active level during the pulse and its complement otherwise.
- R8: In a write to 0x18, top byte 0xA5 sets bit 31 and 0x5A clears it. Top byte 0xA8 sets bit 30 and 0x8A clears it. Any other top byte leaves bits 31:30 unchanged.
- R9: A write to 0x18 replaces only bits [19:0]. Bits [29:20] keep their value.
- R10: If inhibit is high when the counter expires, control is cleared to 0, the counter stops, and no reset pulse is driven.
- R11: The count word ignores writes. Word 0x1C reads back what was written. Unmapped words (0x10, 0x14) read 0 and ignore writes. An access with bus_addr[1:0] not equal to 0 reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; bus_rdata is 0 when low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| inhibit | input | 1 | Turns an expiry into a self-disable |
| rst_out | output | 1 | System reset level |
| rst_oe | output | 1 | Output enable of the reset pin |

## Verification
The bench reads the count on successive cycles in both tick modes. An off-by-one in the prescaler or the expiry test shows up as a count that drops a cycle early or late. It counts the exact active cycles of the reset pin after each expiry, so a pulse one cycle short or long, or one that starts on the wrong edge, is reported. Writes are aimed at the traps in the register file:
- a write that leaves the enable bit unchanged, which a naive design would store;
- a near-miss restart key;
- a top byte that is not a code, which must not touch the polarity;
- an expiry under inhibit, which must not pulse the pin;
- a zero width, which must not pulse the pin.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PW_W   = 20;
  localparam int unsigned CTL_W  = 7;

  // word indices (byte offset / 4)
  localparam logic [2:0] W_COUNT  = 3'd0;
  localparam logic [2:0] W_RELOAD = 3'd1;
  localparam logic [2:0] W_KICK   = 3'd2;
  localparam logic [2:0] W_CTRL   = 3'd3;
  localparam logic [2:0] W_PULSE  = 3'd6;
  localparam logic [2:0] W_MASK   = 3'd7;

  localparam int unsigned C_EN  = 0;
  localparam int unsigned C_RST = 1;
  localparam int unsigned C_US  = 4;

  localparam logic [15:0]       KICK_KEY    = 16'h4755;
  localparam logic [DATA_W-1:0] INIT_COUNT  = 32'h03EF1480;
  localparam logic [DATA_W-1:0] INIT_PULSE  = 32'h000000FF;

  function automatic logic key_matches(input logic [DATA_W-1:0] d);
    return d[15:0] == KICK_KEY;
  endfunction

  function automatic logic ctrl_takes(input logic cur_en, input logic [DATA_W-1:0] d);
    return d[C_EN] != cur_en;
  endfunction

  function automatic logic [DATA_W-1:0] pulse_merge(input logic [DATA_W-1:0] old,
                                                    input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] n;
    n = old;
    case (d[31:24])
      8'hA5: n[31] = 1'b1;
      8'h5A: n[31] = 1'b0;
      8'hA8: n[30] = 1'b1;
      8'h8A: n[30] = 1'b0;
      default: ;
    endcase
    n[PW_W-1:0] = d[PW_W-1:0];
    return n;
  endfunction
endpackage

// File: rtl/wdk_tick.sv
module wdk_tick #(
  parameter int unsigned PRESCALE = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic sel_us,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_flat
      assign tick_o = run;
    end else begin : g_pre
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap   = (pre_q == LAST);
      assign tick_o = run && (!sel_us || wrap);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (clr)            pre_q <= '0;
        else if (run && sel_us)  pre_q <= wrap ? '0 : pre_q + 1'b1;
      end

      // R4
      us_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_us && tick_o) |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int unsigned CW = 32,
  parameter logic [CW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          go,
  input  logic [CW-1:0] load_val,
  input  logic          stop,
  input  logic          tick,
  output logic [CW-1:0] count_o,
  output logic          running_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o  = tick && run_q && !load && !stop && (cnt_q <= CW'(1));
  assign count_o   = cnt_q;
  assign running_o = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= go;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (tick && run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  expire_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0 && !run_q));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int unsigned WW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] width,
  output logic          active_o
);
  logic [WW-1:0] left_q;
  assign active_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         left_q <= '0;
    else if (start)     left_q <= width;
    else if (active_o)  left_q <= left_q - 1'b1;
  end

  // R6
  start_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && width != '0) |=> active_o);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int unsigned PRESCALE = 24,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              inhibit,
  output logic              rst_out,
  output logic              rst_oe
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [DATA_W-1:0] reload_q, pulse_q, mask_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic [IW-1:0]     widx;
  logic              acc_ok;
  logic [2:0]        w3;
  logic wr_reload, wr_kick, wr_ctrl, wr_pulse, wr_mask;
  logic kick_go, ctrl_apply, en_rise, en_fall;
  logic tick, running, expire, pulse_start, pulse_on;
  logic [DATA_W-1:0] count;

  assign widx   = bus_addr[ADDR_W-1:2];
  assign acc_ok = (bus_addr[1:0] == 2'b00) && (int'(widx) < 8);
  assign w3     = widx[2:0];

  assign wr_reload = bus_wr && acc_ok && (w3 == W_RELOAD);
  assign wr_kick   = bus_wr && acc_ok && (w3 == W_KICK);
  assign wr_ctrl   = bus_wr && acc_ok && (w3 == W_CTRL);
  assign wr_pulse  = bus_wr && acc_ok && (w3 == W_PULSE);
  assign wr_mask   = bus_wr && acc_ok && (w3 == W_MASK);

  assign kick_go    = wr_kick && key_matches(bus_wdata);
  assign ctrl_apply = wr_ctrl && ctrl_takes(ctrl_q[C_EN], bus_wdata);
  assign en_rise    = ctrl_apply &&  bus_wdata[C_EN];
  assign en_fall    = ctrl_apply && !bus_wdata[C_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= INIT_COUNT;
      pulse_q  <= INIT_PULSE;
      mask_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_pulse)  pulse_q  <= pulse_merge(pulse_q, bus_wdata);
      if (wr_mask)   mask_q   <= bus_wdata;
      if (ctrl_apply)              ctrl_q <= bus_wdata[CTL_W-1:0];
      else if (expire && inhibit)  ctrl_q <= '0;
    end
  end

  wdk_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(kick_go || en_rise), .run(running),
    .sel_us(ctrl_q[C_US]), .tick_o(tick)
  );

  wdk_count #(.CW(DATA_W), .INIT(INIT_COUNT)) u_count (
    .clk(clk), .rst_n(rst_n), .load(kick_go || en_rise),
    .go(en_rise || ctrl_q[C_EN]), .load_val(reload_q), .stop(en_fall),
    .tick(tick), .count_o(count), .running_o(running), .expire_o(expire)
  );

  assign pulse_start = expire && !inhibit && ctrl_q[C_RST];

  wdk_pulse #(.WW(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(pulse_start),
    .width(pulse_q[PW_W-1:0]), .active_o(pulse_on)
  );

  assign rst_out = pulse_on ? pulse_q[31] : !pulse_q[31];
  assign rst_oe  = pulse_q[30] || pulse_on;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && acc_ok) begin
      case (w3)
        W_COUNT:  bus_rdata = count;
        W_RELOAD: bus_rdata = reload_q;
        W_CTRL:   bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctrl_q};
        W_PULSE:  bus_rdata = pulse_q;
        W_MASK:   bus_rdata = mask_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R10
  inhibit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && inhibit) |=> (ctrl_q == '0 && !pulse_on));
  // R8
  pulse_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(pulse_q));
  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> $past(expire && !inhibit));
  // R3
  ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[C_EN] == ctrl_q[C_EN] && !(expire && inhibit)) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/100ps
module sim_keyed_wdog;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        inhibit = 1'b0;
  logic        rst_out, rst_oe;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  keyed_wdog #(.PRESCALE(PRE), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .inhibit(inhibit), .rst_out(rst_out), .rst_oe(rst_oe)
  );

  // monitor: pops scoreboard entries as reads appear on the bus
  always @(negedge clk) begin
    #1;
    if (bus_rd) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: addr=%h got=%h exp=%h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pin(input logic eo, input logic eoe, input string t);
    checks++;
    if (rst_out !== eo || rst_oe !== eoe) begin
      errors++;
      $display("FAIL %s: out/oe got=%b%b exp=%b%b", t, rst_out, rst_oe, eo, eoe);
    end
  endtask

  // watch pins for 10 cycles after a start event; active window [lo,hi]
  task automatic pulse_win(input int lo, input int hi, input logic act_lvl,
                           input logic pp, input string t);
    for (int k = 0; k < 10; k++) begin
      logic on;
      @(negedge clk); #1;
      on = (k >= lo && k <= hi);
      pin(on ? act_lvl : !act_lvl, pp | on, t);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung got=timeout exp=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, 32'h03EF1480, "R1 count");
    rd(5'h04, 32'h03EF1480, "R1 reload");
    rd(5'h0C, 32'h0, "R1 ctrl");
    rd(5'h18, 32'h000000FF, "R1 pulse cfg");
    rd(5'h1C, 32'h0, "R1 mask");
    @(negedge clk); #1 pin(1'b1, 1'b0, "R1 pin idle");

    // R11 map rules
    wr(5'h00, 32'h55);
    rd(5'h00, 32'h03EF1480, "R11 count read-only");
    wr(5'h1C, 32'hDEADBEEF);
    rd(5'h1C, 32'hDEADBEEF, "R11 mask rw");
    wr(5'h10, 32'h1234);
    rd(5'h10, 32'h0, "R11 unmapped");
    wr(5'h05, 32'h77);
    rd(5'h04, 32'h03EF1480, "R11 misaligned write");
    rd(5'h06, 32'h0, "R11 misaligned read");

    // R2 key
    wr(5'h04, 32'd10);
    wr(5'h08, 32'h00004756);
    rd(5'h00, 32'h03EF1480, "R2 bad key");
    wr(5'h08, 32'hFFFF4755);
    rd(5'h00, 32'd10, "R2 key load");
    rd(5'h00, 32'd10, "R2 disabled stays");
    rd(5'h08, 32'h0, "R2 kick reads 0");

    // R3 dropped write, R4 microsecond tick
    wr(5'h0C, 32'h12);
    rd(5'h0C, 32'h0, "R3 drop same enable");
    wr(5'h0C, 32'h11);
    for (int k = 0; k < 9; k++)
      rd(5'h00, 32'(10 - k / PRE), "R4 us tick count");
    wr(5'h0C, 32'h13);
    rd(5'h0C, 32'h11, "R3 drop while enabled");
    wr(5'h0C, 32'h00);
    rd(5'h0C, 32'h0, "R3 disable applied");
    wr(5'h08, 32'h4755);
    for (int k = 0; k < 3; k++) rd(5'h00, 32'd10, "R3 frozen when off");

    // R4 raw tick, R5 expiry stop, R6 no pulse without bit1
    wr(5'h0C, 32'h01);
    for (int k = 0; k < 13; k++)
      rd(5'h00, (k < 10) ? 32'(10 - k) : 32'd0, "R5 raw count to zero");
    @(negedge clk); #1 pin(1'b1, 1'b0, "R6 no pulse bit1 clear");
    wr(5'h0C, 32'h00);

    // R9 width, R6 pulse, R7 default polarity
    wr(5'h04, 32'd3);
    wr(5'h18, 32'h00000004);
    rd(5'h18, 32'h00000004, "R9 low field");
    wr(5'h0C, 32'h03);
    pulse_win(3, 6, 1'b0, 1'b0, "R6 pulse low open-drain");
    rd(5'h00, 32'd0, "R5 stopped at 0");

    // R8 codes, R9 upper bits kept, R7 push-pull high
    wr(5'h18, 32'hA5000002);
    rd(5'h18, 32'h80000002, "R8 A5");
    wr(5'h18, 32'hA8000002);
    rd(5'h18, 32'hC0000002, "R8 A8");
    wr(5'h18, 32'h12F00003);
    rd(5'h18, 32'hC0000003, "R9 other byte");
    @(negedge clk); #1 pin(1'b0, 1'b1, "R7 idle push-pull high");
    wr(5'h08, 32'h4755);
    pulse_win(3, 5, 1'b1, 1'b1, "R7 pulse high push-pull");

    // R10 inhibit
    wr(5'h18, 32'h5A000003);
    rd(5'h18, 32'h40000003, "R8 5A");
    inhibit = 1'b1;
    wr(5'h08, 32'h4755);
    pulse_win(99, 99, 1'b0, 1'b1, "R10 no pulse");
    rd(5'h0C, 32'h0, "R10 ctrl cleared");
    rd(5'h00, 32'h0, "R10 stopped");
    inhibit = 1'b0;

    // R8 8A, R6 zero width
    wr(5'h18, 32'h8A000000);
    rd(5'h18, 32'h00000000, "R8 8A");
    wr(5'h0C, 32'h03);
    pulse_win(99, 99, 1'b0, 1'b0, "R6 zero width");
    report();
  end
endmodule